// File: doc/BRIEF.md
# Single-Bus Microcoded Processor Datapath

This block is a small processor datapath in which every register shares one internal bus. A microcode store of preloadable rows controls it. Each row runs as one step. In a step, a set of switch bits chooses at most one register to drive the bus and any number of registers to load from it. A three-bit field selects an ALU function and a two-bit field selects a memory action. The registers are the program counter, the instruction register, two user registers, an operand register, a result register, a memory address register and a memory buffer register. Data is 8 bits wide. The instruction holds a 3-bit opcode above a 5-bit address field.

Rows run in order with no branching. The row counter wraps from the last row back to row 0, so the depth must be a power of two. Memory traffic uses a one-cycle request pulse and a done pulse that returns a variable number of cycles later. A read reaches the memory buffer register when done arrives. A wait action in a row makes sequencing pause until the outstanding memory operation finishes. While the block is in reset, the microcode store is written through a row-load port.

Top module: `ucpu_core`

## Requirements
- R1: While reset is asserted, the program counter, the instruction, user and result registers, the row counter, the stall flag and the memory request are all zero.
- R2: In one step the value of the single driving register reaches every register whose load switch is set in that step. All of these loads are visible in the next cycle.
- R3: The instruction register loads the full 8-bit word. Driving it onto the bus places only the low 5 address bits there, with the upper 3 bits zero.
- R4: The ALU field codes are 0 none, 1 add (operand + bus), 2 subtract (operand − bus), 3 increment (bus + 1) and 4 decrement (bus − 1). The arithmetic is modulo 256 and the result register updates at the end of the step.
- R5: If a row has a nonzero ALU code but the bus-to-ALU switch is clear, the result register keeps its value.
- R6: Memory field code 1 is read and code 2 is write. The operation issues at the end of its step. In the next cycle mem_req is high for exactly one cycle, mem_addr carries the address register as loaded by that step, and for a write mem_we is 1 and mem_wdata carries the buffer register.
- R7: Memory field code 3 is wait. If an operation is outstanding and done has not arrived, the row's transfers happen once. After that the row counter holds, stall_o is 1 and no register loads until the cycle in which done is seen. The following row then runs in the next cycle.
- R8: When a read completes, the returned data is in the memory buffer register in the cycle after done.
- R9: A wait with no outstanding operation does not stall, and the next row runs in the next cycle.
- R10: When not stalled, the row counter advances by one each cycle and wraps from the last row to row 0.
- R11: A microcode word is 19 bits. Bits 18:17 hold the memory field and bits 16:14 hold the ALU field. The switch bits are: 0 IR load, 1 IR address drive, 2 PC drive, 3 PC load, 4 R1 drive, 5 R1 load, 6 R2 drive, 7 R2 load, 8 operand load, 9 bus to ALU, 10 result drive, 11 address-register load, 12 buffer drive, 13 buffer load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uc_we | input | 1 | Write strobe for one microcode row |
| uc_addr | input | 4 | Row index to write |
| uc_word | input | 19 | Microcode word to write |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 8 | Memory address (address register) |
| mem_wdata | output | 8 | Write data (buffer register) |
| mem_rdata | input | 8 | Read data, valid with mem_done |
| mem_done | input | 1 | Outstanding memory operation finished |
| pc_o | output | 8 | Program counter |
| ir_o | output | 8 | Instruction register |
| r1_o | output | 8 | User register 1 |
| r2_o | output | 8 | User register 2 |
| res_o | output | 8 | ALU result register |
| upc_o | output | 4 | Current microcode row |
| stall_o | output | 1 | Sequencing frozen on a wait |

## Verification
The bench targets the stall edges. It checks that the wait row's own transfers run exactly once, that loads stay frozen during the stall, and that the next row starts in the cycle right after done; a design that re-ran the row or released one cycle late would corrupt the program counter or the row timing. It checks that a read requested in the same step that loads the address register goes out with the new address, not the stale one. It checks that an ALU code without the bus-to-ALU switch leaves the result register alone. It checks that a wait with nothing outstanding does not freeze sequencing forever. It runs a fetch followed by an indexed subtract with two memory latencies and compares the user register and the program counter against a reference model.

// File: rtl/ucpu_pkg.sv
package ucpu_pkg;

  localparam int SW_N     = 14;
  localparam int ALU_FW   = 3;
  localparam int MEM_FW   = 2;
  localparam int UW       = SW_N + ALU_FW + MEM_FW;
  localparam int NUM_UREG = 2;

  // switch bit positions inside a microcode word
  localparam int SW_IR_LD    = 0;
  localparam int SW_IRA_OE   = 1;
  localparam int SW_PC_OE    = 2;
  localparam int SW_PC_LD    = 3;
  localparam int SW_UREG_OE0 = 4;   // user reg g drives at 4+2g
  localparam int SW_UREG_LD0 = 5;   // user reg g loads  at 5+2g
  localparam int SW_OPND_LD  = 8;
  localparam int SW_ALU_IN   = 9;
  localparam int SW_RES_OE   = 10;
  localparam int SW_MAR_LD   = 11;
  localparam int SW_MBR_OE   = 12;
  localparam int SW_MBR_LD   = 13;

  localparam logic [SW_N-1:0] SW_LD_MASK =
    SW_N'((1 << SW_IR_LD) | (1 << SW_PC_LD) | (1 << SW_UREG_LD0) |
          (1 << (SW_UREG_LD0 + 2)) | (1 << SW_OPND_LD) |
          (1 << SW_MAR_LD) | (1 << SW_MBR_LD));

  typedef enum logic [ALU_FW-1:0] {
    ALU_NOP = 3'd0,
    ALU_ADD = 3'd1,
    ALU_SUB = 3'd2,
    ALU_INC = 3'd3,
    ALU_DEC = 3'd4
  } alu_op_e;

  typedef enum logic [MEM_FW-1:0] {
    MEM_NOP   = 2'd0,
    MEM_READ  = 2'd1,
    MEM_WRITE = 2'd2,
    MEM_WAIT  = 2'd3
  } mem_op_e;

  typedef struct packed {
    mem_op_e         mem;
    alu_op_e         alu;
    logic [SW_N-1:0] sw;
  } uword_t;

  function automatic logic alu_active(alu_op_e op);
    return (op == ALU_ADD) || (op == ALU_SUB) ||
           (op == ALU_INC) || (op == ALU_DEC);
  endfunction

endpackage

// File: rtl/ucpu_ustore.sv
module ucpu_ustore import ucpu_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  uword_t        wr_word,
  input  logic [AW-1:0] rd_addr,
  output uword_t        rd_word
);

  uword_t rows_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) rows_q[wr_addr] <= wr_word;
  end

  assign rd_word = rows_q[rd_addr];

endmodule

// File: rtl/ucpu_seq.sv
module ucpu_seq import ucpu_pkg::*; #(
  parameter int UPC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mem_op_e          mem_op,
  input  logic             mem_done,
  output logic [UPC_W-1:0] upc_q,
  output logic             stall_q,
  output logic             exec,
  output logic             hold,
  output logic             issue,
  output logic             rd_fill,
  output logic             req_q,
  output logic             we_q
);

  logic pend_q;
  logic pend_rd_q;
  logic is_xfer;
  logic is_wait;

  assign is_xfer = (mem_op == MEM_READ) || (mem_op == MEM_WRITE);
  assign is_wait = (mem_op == MEM_WAIT);

  // a row's transfers run only in its first cycle
  assign exec    = !stall_q;
  assign hold    = stall_q ? !mem_done : (is_wait && pend_q && !mem_done);
  assign issue   = exec && is_xfer && !pend_q;
  assign rd_fill = mem_done && pend_q && pend_rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc_q     <= '0;
      stall_q   <= 1'b0;
      pend_q    <= 1'b0;
      pend_rd_q <= 1'b0;
      req_q     <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      stall_q <= hold;
      if (!hold) upc_q <= upc_q + UPC_W'(1);
      req_q <= issue;
      if (issue) we_q <= (mem_op == MEM_WRITE);
      if (mem_done && pend_q) begin
        pend_q    <= 1'b0;
        pend_rd_q <= 1'b0;
      end else if (issue) begin
        pend_q    <= 1'b1;
        pend_rd_q <= (mem_op == MEM_READ);
      end
    end
  end

endmodule

// File: rtl/ucpu_datapath.sv
module ucpu_datapath import ucpu_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int ADR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW_N-1:0]   sw,
  input  alu_op_e           alu_op,
  input  logic              exec,
  input  logic              rd_fill,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] pc_q,
  output logic [DATA_W-1:0] ir_q,
  output logic [DATA_W-1:0] mar_q,
  output logic [DATA_W-1:0] mbr_q,
  output logic [DATA_W-1:0] res_q,
  output logic [DATA_W-1:0] r1_q,
  output logic [DATA_W-1:0] r2_q,
  output logic [DATA_W-1:0] bus_val,
  output logic              res_we,
  output logic              load_any
);

  localparam int DRV_N = 4 + NUM_UREG;
  localparam int OPC_W = DATA_W - ADR_W;

  function automatic logic [DATA_W-1:0] alu_eval(alu_op_e op,
                                                 logic [DATA_W-1:0] b,
                                                 logic [DATA_W-1:0] o);
    case (op)
      ALU_ADD: return o + b;
      ALU_SUB: return o - b;
      ALU_INC: return b + DATA_W'(1);
      ALU_DEC: return b - DATA_W'(1);
      default: return '0;
    endcase
  endfunction

  logic [DATA_W-1:0] opnd_q;
  logic [DATA_W-1:0] ureg_q [NUM_UREG];
  logic [DRV_N-1:0]  drv_en;
  logic [DATA_W-1:0] drv_val [DRV_N];
  logic [SW_N-1:0]   ld;

  assign ld = sw & {SW_N{exec}};

  always_comb begin
    drv_en[0]  = ld[SW_IRA_OE];
    drv_val[0] = {{OPC_W{1'b0}}, ir_q[ADR_W-1:0]};
    drv_en[1]  = ld[SW_PC_OE];
    drv_val[1] = pc_q;
    drv_en[2]  = ld[SW_RES_OE];
    drv_val[2] = res_q;
    drv_en[3]  = ld[SW_MBR_OE];
    drv_val[3] = mbr_q;
    for (int i = 0; i < NUM_UREG; i++) begin
      drv_en[4+i]  = ld[SW_UREG_OE0 + 2*i];
      drv_val[4+i] = ureg_q[i];
    end
  end

  always_comb begin
    bus_val = '0;
    for (int i = 0; i < DRV_N; i++) begin
      if (drv_en[i]) bus_val = bus_val | drv_val[i];
    end
  end

  assign res_we   = ld[SW_ALU_IN] && alu_active(alu_op);
  assign load_any = (|(ld & SW_LD_MASK)) || res_we;

  for (genvar g = 0; g < NUM_UREG; g++) begin : g_ureg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ureg_q[g] <= '0;
      else if (ld[SW_UREG_LD0 + 2*g])     ureg_q[g] <= bus_val;
    end
  end

  assign r1_q = ureg_q[0];
  assign r2_q = ureg_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      ir_q   <= '0;
      opnd_q <= '0;
      mar_q  <= '0;
      mbr_q  <= '0;
      res_q  <= '0;
    end else begin
      if (ld[SW_PC_LD])   pc_q   <= bus_val;
      if (ld[SW_IR_LD])   ir_q   <= bus_val;
      if (ld[SW_OPND_LD]) opnd_q <= bus_val;
      if (ld[SW_MAR_LD])  mar_q  <= bus_val;
      if (rd_fill)            mbr_q <= rd_data;
      else if (ld[SW_MBR_LD]) mbr_q <= bus_val;
      if (res_we) res_q <= alu_eval(alu_op, bus_val, opnd_q);
    end
  end

endmodule

// File: rtl/ucpu_core.sv
module ucpu_core import ucpu_pkg::*; #(
  parameter int  UC_DEPTH = 16,
  parameter int  DATA_W   = 8,
  parameter int  OPC_W    = 3,
  localparam int UPC_W    = $clog2(UC_DEPTH),
  localparam int ADR_W    = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uc_we,
  input  logic [UPC_W-1:0]  uc_addr,
  input  logic [UW-1:0]     uc_word,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_done,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] r1_o,
  output logic [DATA_W-1:0] r2_o,
  output logic [DATA_W-1:0] res_o,
  output logic [UPC_W-1:0]  upc_o,
  output logic              stall_o
);

  uword_t            row;
  logic              seq_exec;
  logic              seq_hold;
  logic              issue_evt;
  logic              rd_fill;
  logic              res_we;
  logic              load_any;
  logic [DATA_W-1:0] bus_val;
  logic [DATA_W-1:0] mar_q;
  logic [DATA_W-1:0] mbr_q;

  ucpu_ustore #(.DEPTH(UC_DEPTH), .AW(UPC_W)) u_store (
    .clk     (clk),
    .wr_en   (uc_we),
    .wr_addr (uc_addr),
    .wr_word (uword_t'(uc_word)),
    .rd_addr (upc_o),
    .rd_word (row)
  );

  ucpu_seq #(.UPC_W(UPC_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_op   (row.mem),
    .mem_done (mem_done),
    .upc_q    (upc_o),
    .stall_q  (stall_o),
    .exec     (seq_exec),
    .hold     (seq_hold),
    .issue    (issue_evt),
    .rd_fill  (rd_fill),
    .req_q    (mem_req),
    .we_q     (mem_we)
  );

  ucpu_datapath #(.DATA_W(DATA_W), .ADR_W(ADR_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw       (row.sw),
    .alu_op   (row.alu),
    .exec     (seq_exec),
    .rd_fill  (rd_fill),
    .rd_data  (mem_rdata),
    .pc_q     (pc_o),
    .ir_q     (ir_o),
    .mar_q    (mar_q),
    .mbr_q    (mbr_q),
    .res_q    (res_o),
    .r1_q     (r1_o),
    .r2_q     (r2_o),
    .bus_val  (bus_val),
    .res_we   (res_we),
    .load_any (load_any)
  );

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;

endmodule

// File: rtl/ucpu_core_chk.sv
module ucpu_core_chk #(
  parameter int UPC_W  = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_done,
  input logic [UPC_W-1:0]  upc,
  input logic              stall,
  input logic              hold,
  input logic              issue,
  input logic [DATA_W-1:0] res,
  input logic              res_we,
  input logic              load_any
);

  assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_req_from_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(issue));

  assert_stall_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !mem_done) |=> $stable(upc));

  assert_stall_noload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !load_any);

  assert_stall_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && mem_done) |=> !stall);

  assert_upc_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (upc == UPC_W'($past(upc) + 1'b1)));

  assert_res_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !res_we |=> $stable(res));

endmodule

bind ucpu_core ucpu_core_chk #(.UPC_W(UPC_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_req  (mem_req),
  .mem_done (mem_done),
  .upc      (upc_o),
  .stall    (stall_o),
  .hold     (seq_hold),
  .issue    (issue_evt),
  .res      (res_o),
  .res_we   (res_we),
  .load_any (load_any)
);

// File: tb/ucpu_core_test.sv
module ucpu_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS       = 16;
  localparam int WD_LIMIT   = 20000;

  // switch masks (bit positions per R11)
  localparam int B_IRLD = 1 << 0,  B_IRA = 1 << 1,  B_PCO = 1 << 2,  B_PCL = 1 << 3;
  localparam int B_R1O  = 1 << 4,  B_R1L = 1 << 5,  B_R2O = 1 << 6,  B_R2L = 1 << 7;
  localparam int B_OPL  = 1 << 8,  B_ALU = 1 << 9,  B_RSO = 1 << 10, B_MARL = 1 << 11;
  localparam int B_MBO  = 1 << 12, B_MBL = 1 << 13;
  localparam int A_ADD = 1, A_SUB = 2, A_INC = 3, A_DEC = 4;
  localparam int M_RD = 1, M_WR = 2, M_WT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        uc_we = 1'b0;
  logic [3:0]  uc_addr = '0;
  logic [18:0] uc_word = '0;
  logic        mem_req, mem_we;
  logic [7:0]  mem_addr, mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_done = 1'b0;
  logic [7:0]  pc_o, ir_o, r1_o, r2_o, res_o;
  logic [3:0]  upc_o;
  logic        stall_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int lat    = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucpu_core uut (
    .clk(clk), .rst_n(rst_n), .uc_we(uc_we), .uc_addr(uc_addr), .uc_word(uc_word),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_done(mem_done), .pc_o(pc_o), .ir_o(ir_o),
    .r1_o(r1_o), .r2_o(r2_o), .res_o(res_o), .upc_o(upc_o), .stall_o(stall_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [18:0] uw(input int sw, input int alu, input int mo);
    return {mo[1:0], alu[2:0], sw[13:0]};
  endfunction

  // ---------------- memory model ----------------
  logic [7:0] mem [256];
  int         mcnt = 0;
  logic [7:0] maddr_p;
  logic       mwe_p;

  always @(negedge clk) begin
    if (mem_done) mem_done = 1'b0;
    if (!rst_n) begin
      mcnt = 0;
    end else if (mem_req) begin
      mcnt    = lat;
      maddr_p = mem_addr;
      mwe_p   = mem_we;
      if (mem_we) mem[mem_addr] = mem_wdata;
    end else if (mcnt > 0) begin
      mcnt--;
      if (mcnt == 0) begin
        mem_done = 1'b1;
        if (!mwe_p) mem_rdata = mem[maddr_p];
      end
    end
  end

  // ---------------- reference model ----------------
  logic [18:0] m_uc [ROWS];
  int m_pc, m_ir, m_r1, m_r2, m_op, m_res, m_mar, m_mbr, m_upc;
  int m_stall, m_pend, m_pendrd, m_req, m_we;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_ir = 0; m_r1 = 0; m_r2 = 0; m_op = 0; m_res = 0; m_mar = 0;
      m_mbr = 0; m_upc = 0; m_stall = 0; m_pend = 0; m_pendrd = 0; m_req = 0; m_we = 0;
    end else begin
      int sw, alu, mo, bus, run, hold, iss, done;
      sw   = int'(m_uc[m_upc][13:0]);
      alu  = int'(m_uc[m_upc][16:14]);
      mo   = int'(m_uc[m_upc][18:17]);
      done = (mem_done && m_pend) ? 1 : 0;
      run  = m_stall ? 0 : 1;
      hold = m_stall ? !done : (mo == M_WT && m_pend && !done);
      iss  = run && (mo == M_RD || mo == M_WR) && !m_pend;
      bus  = 0;
      if (run) begin
        if (sw & B_IRA) bus = bus | (m_ir % 32);
        if (sw & B_PCO) bus = bus | m_pc;
        if (sw & B_RSO) bus = bus | m_res;
        if (sw & B_MBO) bus = bus | m_mbr;
        if (sw & B_R1O) bus = bus | m_r1;
        if (sw & B_R2O) bus = bus | m_r2;
        if ((sw & B_ALU) && alu >= 1 && alu <= 4) begin
          case (alu)
            A_ADD:   m_res = (m_op + bus) & 255;
            A_SUB:   m_res = (m_op - bus) & 255;
            A_INC:   m_res = (bus + 1) & 255;
            default: m_res = (bus - 1) & 255;
          endcase
        end
        if (sw & B_IRLD) m_ir  = bus;
        if (sw & B_PCL)  m_pc  = bus;
        if (sw & B_R1L)  m_r1  = bus;
        if (sw & B_R2L)  m_r2  = bus;
        if (sw & B_OPL)  m_op  = bus;
        if (sw & B_MARL) m_mar = bus;
        if (sw & B_MBL)  m_mbr = bus;
      end
      if (done && m_pendrd) m_mbr = int'(mem_rdata);
      m_req = iss;
      if (iss) m_we = (mo == M_WR);
      if (done) begin m_pend = 0; m_pendrd = 0; end
      else if (iss) begin m_pend = 1; m_pendrd = (mo == M_RD); end
      m_stall = hold;
      if (!hold) m_upc = (m_upc + 1) % ROWS;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 row counter", upc_o, m_upc);
      chk("R7 stall flag", stall_o, m_stall);
      chk("R2 pc", pc_o, m_pc);
      chk("R3 ir", ir_o, m_ir);
      chk("R2 r1", r1_o, m_r1);
      chk("R2 r2", r2_o, m_r2);
      chk("R4 result", res_o, m_res);
      chk("R6 request", mem_req, m_req);
      if (mem_req) begin
        chk("R6 write flag", mem_we, m_we);
        chk("R6 address", mem_addr, m_mar);
        if (mem_we) chk("R6 write data", mem_wdata, m_mbr);
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic load_prog(input logic [18:0] prog [ROWS]);
    rst_n = 1'b0;
    for (int i = 0; i < ROWS; i++) begin
      @(negedge clk);
      uc_we = 1'b1; uc_addr = 4'(i); uc_word = prog[i];
      m_uc[i] = prog[i];
    end
    @(negedge clk);
    uc_we = 1'b0;
    chk("R1 reset pc", pc_o, 0);
    chk("R1 reset ir", ir_o, 0);
    chk("R1 reset r1", r1_o, 0);
    chk("R1 reset r2", r2_o, 0);
    chk("R1 reset result", res_o, 0);
    chk("R1 reset row", upc_o, 0);
    chk("R1 reset stall", stall_o, 0);
    chk("R1 reset request", mem_req, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_row(input int n);
    do @(negedge clk); while (!(upc_o == 4'(n) && !stall_o));
  endtask

  function automatic void mem_init();
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
  endfunction

  initial begin
    logic [18:0] pa [ROWS];
    logic [18:0] pb [ROWS];
    int exp_r1;

    // phase A: fetch, then subtract R1, mem[R2 + addr]; reload R2 from mem[pc]
    for (int i = 0; i < ROWS; i++) pa[i] = '0;
    pa[0]  = uw(B_PCO | B_MARL | B_ALU, A_INC, M_RD);
    pa[1]  = uw(B_RSO | B_PCL, 0, M_WT);
    pa[2]  = uw(B_MBO | B_IRLD, 0, 0);
    pa[3]  = uw(B_R2O | B_OPL, 0, 0);
    pa[4]  = uw(B_IRA | B_ALU, A_ADD, 0);
    pa[5]  = uw(B_RSO | B_MARL, 0, M_RD);
    pa[6]  = uw(B_R1O | B_OPL, 0, M_WT);
    pa[7]  = uw(B_MBO | B_ALU, A_SUB, 0);
    pa[8]  = uw(B_RSO | B_R1L, 0, 0);
    pa[9]  = uw(B_PCO | B_MARL, 0, M_RD);
    pa[10] = uw(0, 0, M_WT);
    pa[11] = uw(B_MBO | B_R2L, 0, 0);

    lat = 8;
    mem_init();
    mem[0] = 8'h65;   // opcode 3, address 5
    mem[1] = 8'h43;   // opcode 2, address 3
    mem[5] = 8'h2C;
    load_prog(pa);

    wait_row(9);
    chk("R8 R4 subtract result in r1", r1_o, 8'hD4);
    chk("R2 pc after fetch", pc_o, 1);
    wait_row(15);
    @(negedge clk);
    chk("R10 wrap to row 0", upc_o, 0);
    wait_row(9);
    exp_r1 = (8'hD4 - int'(mem[8'h43 + 3])) & 255;
    chk("R8 indexed subtract second pass", r1_o, exp_r1);
    chk("R2 pc second pass", pc_o, 2);

    // phase B: ALU functions, gating, waits and a write
    for (int i = 0; i < ROWS; i++) pb[i] = '0;
    pb[0]  = uw(B_PCO | B_MARL | B_ALU, A_INC, M_RD);
    pb[1]  = uw(0, 0, M_WT);
    pb[2]  = uw(B_MBO | B_IRLD | B_R1L, 0, 0);
    pb[3]  = uw(B_IRA | B_R2L | B_ALU, A_DEC, 0);
    pb[4]  = uw(B_R1O | B_OPL, 0, 0);
    pb[5]  = uw(B_R2O | B_ALU, A_ADD, 0);
    pb[6]  = uw(B_R2O, A_SUB, 0);
    pb[7]  = uw(B_RSO | B_MBL, 0, M_WT);
    pb[8]  = uw(B_R2O | B_MARL, 0, M_WR);
    pb[9]  = uw(0, 0, M_WT);
    pb[10] = uw(B_R1O | B_ALU, A_SUB, 0);
    pb[11] = uw(B_RSO | B_PCL, 0, 0);
    pb[12] = uw(B_PCO | B_ALU, A_INC, 0);
    pb[13] = uw(B_RSO | B_PCL, 0, 0);

    lat = 1;
    mem_init();
    mem[0] = 8'hE9;   // opcode 7, address 9
    load_prog(pb);

    wait_row(1);
    @(negedge clk);
    chk("R7 stall asserted on wait", stall_o, 1);
    chk("R7 row held on wait", upc_o, 1);
    @(negedge clk);
    chk("R7 next row after done", upc_o, 2);
    chk("R7 stall released", stall_o, 0);
    wait_row(4);
    chk("R3 full word in ir", ir_o, 8'hE9);
    chk("R8 R2 read data into r1 with ir", r1_o, 8'hE9);
    chk("R3 address field only on bus", r2_o, 8'h09);
    chk("R4 decrement", res_o, 8'h08);
    wait_row(6);
    chk("R4 add", res_o, 8'hF2);
    wait_row(7);
    chk("R5 result kept without bus-to-ALU", res_o, 8'hF2);
    @(negedge clk);
    chk("R9 idle wait does not stall", upc_o, 8);
    wait_row(9);
    chk("R6 request pulse", mem_req, 1);
    chk("R6 write flag", mem_we, 1);
    chk("R6 address from same step", mem_addr, 8'h09);
    chk("R6 write data", mem_wdata, 8'hF2);
    @(negedge clk);
    chk("R6 single-cycle request", mem_req, 0);
    wait_row(10);
    chk("R6 memory written", mem[9], 8'hF2);
    wait_row(12);
    chk("R4 subtract to zero", res_o, 8'h00);
    chk("R2 pc from result", pc_o, 8'h00);
    wait_row(14);
    chk("R4 increment", pc_o, 8'h01);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule